// File: doc/BRIEF.md
# Word-at-a-time Transmit Bridge from CPU Writes to a Packet Stream

This block sits between an embedded processor's simple write bus and an outgoing packet stream. Software assembles each outgoing frame one 32-bit word at a time. It writes a frame length word first. Then, for every word of the frame, it writes a sideband word and then the payload word. The sideband word carries the destination and source port codes, a byte-valid mask and an end-of-frame flag. The sideband is only held when it is written. Each payload write turns the held sideband and the payload into one beat and places that beat in an internal packet buffer. The buffer drains onto a valid/ready stream with data, keep, user and last fields.

The write bus has three word slots, chosen by a 2-bit word select: 0 is payload, 1 is sideband, 2 is frame length, and 3 is unused. Sideband fields sit at fixed bit positions that downstream logic decodes. Port codes are one-hot within a byte: bit 0 and bit 1 are the first network port and the first CPU port, and the pairs repeat upward to bit 7. The payload word arrives in big-endian lane order, so its most significant byte is the first byte of the frame. The sideband and length words are taken as written.

Back-pressure rules are as follows. A beat stays on the stream, unchanged, until it is taken by `tvalid && tready`. When the buffer is full, `bus_wready` drops for a payload write, and the write waits on the bus until a slot frees. Sideband, length and unused-slot writes are never stalled, and no write is ever dropped.

Top module: `pio_tx_stream_bridge`

## Requirements
- R1: After reset, `m_tvalid` is 0 and `bus_wready` is 1 for every word select.
- R2: A sideband write (select 1) produces no beat. The held sideband is applied to every later payload write until the next sideband write.
- R3: Writes to select 2 (length) and select 3 (unused) produce no beat and leave the held sideband unchanged.
- R4: A payload write (select 0) with word W produces a beat whose `m_tdata[7:0]` is W[31:24], `m_tdata[15:8]` is W[23:16], `m_tdata[23:16]` is W[15:8] and `m_tdata[31:24]` is W[7:0].
- R5: For a held sideband S, the beat carries `m_tkeep` = S[3:0], `m_tlast` = S[7], `m_tuser[7:0]` = S[23:16] (source port) and `m_tuser[15:8]` = S[31:24] (destination port). Bits S[15:8] and S[6:4] have no effect.
- R6: Beats leave the stream in the order their payload writes were accepted.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` stays 1 and the beat fields stay stable.
- R8: When the buffer holds DEPTH beats, `bus_wready` is 0 for select 0 and 1 for any other select. A stalled payload write completes once a beat drains, and its beat is not lost.
- R9: A payload write accepted in the same cycle as a stream transfer both stores its beat and releases the head beat.
- R10: A beat from a payload write accepted at one clock edge is presented on the stream (`m_tvalid` 1) right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wvalid | input | 1 | Write request |
| bus_wsel | input | 2 | Word select: 0 payload, 1 sideband, 2 length, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_wready | output | 1 | Write accepted when high together with bus_wvalid |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Beat payload, lane 0 holds the first byte |
| m_tkeep | output | 4 | Byte-valid mask |
| m_tuser | output | 16 | {destination port, source port} |
| m_tlast | output | 1 | End of frame |

## Verification
Two functions can fall in the same cycle: a payload write pushing into the buffer, and the stream popping the head beat. The bench provokes this in two ways. It raises `m_tready` in the same cycle as a payload write into a partly filled buffer. It also releases a stalled write at full occupancy by letting the sink drain. The outcome is judged at the stream by two checks: every expected beat appears exactly once in write order, and the total number of beats leaving matches the number of writes. Inside the buffer, the occupancy is checked to stay put across a simultaneous push and pop.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int PORT_W     = 8;
  localparam int BUF_BYTES  = 4096;
  localparam int SEL_W      = 2;

  localparam logic [SEL_W-1:0] SEL_PAYLOAD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SIDEBAND = 2'd1;

  // sideband bit positions decoded by the stream consumer
  localparam int SB_DST_LSB  = 24;
  localparam int SB_SRC_LSB  = 16;
  localparam int SB_LAST_BIT = 7;

  typedef struct packed {
    logic [PORT_W-1:0]     dst;
    logic [PORT_W-1:0]     src;
    logic                  last;
    logic [WORD_BYTES-1:0] keep;
  } sideband_t;

  typedef struct packed {
    logic [2*PORT_W-1:0]   user;
    logic                  last;
    logic [WORD_BYTES-1:0] keep;
    logic [WORD_W-1:0]     data;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);
endpackage

// File: rtl/ptx_write_decode.sv
module ptx_write_decode
  import ptx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wvalid,
  input  logic [SEL_W-1:0] bus_wsel,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic             buf_full,
  output logic             bus_wready,
  output logic             push,
  output beat_t            beat
);
  sideband_t sb_q;
  logic [WORD_W-1:0] swapped;
  logic is_payload;

  assign is_payload = (bus_wsel == SEL_PAYLOAD);
  assign bus_wready = !(is_payload && buf_full);
  assign push       = bus_wvalid && is_payload && !buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_q <= '0;
    end else if (bus_wvalid && bus_wsel == SEL_SIDEBAND) begin
      sb_q.dst  <= bus_wdata[SB_DST_LSB +: PORT_W];
      sb_q.src  <= bus_wdata[SB_SRC_LSB +: PORT_W];
      sb_q.last <= bus_wdata[SB_LAST_BIT];
      sb_q.keep <= bus_wdata[WORD_BYTES-1:0];
    end
  end

  // payload lanes arrive most-significant-first; lane 0 of the stream is byte 0
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign swapped[b*8 +: 8] = bus_wdata[(WORD_BYTES-1-b)*8 +: 8];
  end

  always_comb begin
    beat.user = {sb_q.dst, sb_q.src};
    beat.last = sb_q.last;
    beat.keep = sb_q.keep;
    beat.data = swapped;
  end

  // R3
  sideband_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && bus_wsel != SEL_SIDEBAND) |=> $stable(sb_q));
endmodule

// File: rtl/ptx_beat_fifo.sv
module ptx_beat_fifo #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_MAX);
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_MAX));

  // R9
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/pio_tx_stream_bridge.sv
module pio_tx_stream_bridge
  import ptx_pkg::*;
#(
  parameter int DEPTH = BUF_BYTES / WORD_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wvalid,
  input  logic [SEL_W-1:0]    bus_wsel,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic                bus_wready,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic [WORD_W-1:0]   m_tdata,
  output logic [WORD_BYTES-1:0] m_tkeep,
  output logic [2*PORT_W-1:0] m_tuser,
  output logic                m_tlast
);
  beat_t in_beat, out_beat;
  logic push, pop, full, empty;

  ptx_write_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wvalid (bus_wvalid),
    .bus_wsel   (bus_wsel),
    .bus_wdata  (bus_wdata),
    .buf_full   (full),
    .bus_wready (bus_wready),
    .push       (push),
    .beat       (in_beat)
  );

  ptx_beat_fifo #(.DEPTH(DEPTH), .WIDTH(BEAT_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (in_beat),
    .pop   (pop),
    .dout  (out_beat),
    .full  (full),
    .empty (empty)
  );

  assign m_tvalid = !empty;
  assign pop      = m_tvalid && m_tready;
  assign m_tdata  = out_beat.data;
  assign m_tkeep  = out_beat.keep;
  assign m_tuser  = out_beat.user;
  assign m_tlast  = out_beat.last;

  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                 && $stable(m_tuser) && $stable(m_tlast)));

  // R10
  push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && bus_wready && bus_wsel == SEL_PAYLOAD) |=> m_tvalid);

  // R3
  nonpayload_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_tvalid && bus_wsel != SEL_PAYLOAD) |=> !m_tvalid);
endmodule

// File: tb/pio_tx_stream_bridge_tb_top.sv
module pio_tx_stream_bridge_tb_top;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wvalid = 1'b0;
  logic [1:0] bus_wsel = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic bus_wready;
  logic m_tvalid;
  logic m_tready = 1'b0;
  logic [31:0] m_tdata;
  logic [3:0] m_tkeep;
  logic [15:0] m_tuser;
  logic m_tlast;

  always #10 clk = ~clk;

  pio_tx_stream_bridge #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wvalid(bus_wvalid), .bus_wsel(bus_wsel),
    .bus_wdata(bus_wdata), .bus_wready(bus_wready), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tuser(m_tuser), .m_tlast(m_tlast)
  );

  int n_checks = 0;
  int n_fail = 0;
  int beats_seen = 0;
  string tag = "R6";
  logic [52:0] exp_q [$];
  logic [31:0] held_sb = '0;
  bit done = 0;

  function automatic logic [52:0] expect_beat(input logic [31:0] sb, input logic [31:0] w);
    logic [31:0] d;
    d = {w[7:0], w[15:8], w[23:16], w[31:24]};
    return {sb[31:24], sb[23:16], sb[7], sb[3:0], d};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [31:0] data);
    bit ok;
    @(negedge clk);
    bus_wvalid = 1'b1;
    bus_wsel = sel;
    bus_wdata = data;
    forever begin
      #1 ok = bus_wready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    if (sel == 2'd1) held_sb = data;
    if (sel == 2'd0) exp_q.push_back(expect_beat(held_sb, data));
    @(negedge clk);
    bus_wvalid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    m_tready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    m_tready = 1'b0;
  endtask

  // stream monitor: one check per beat, in order (R6)
  always begin
    @(negedge clk);
    #1;
    if (rst_n && m_tvalid && m_tready) begin
      logic [52:0] got;
      got = {m_tuser, m_tlast, m_tkeep, m_tdata};
      beats_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, tag, "unexpected beat", 64'(got), 64'(0));
      end else begin
        logic [52:0] e;
        e = exp_q.pop_front();
        check(got == e, tag, "beat", 64'(got), 64'(e));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] first_data;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    check(m_tvalid == 1'b0, "R1", "tvalid after reset", 64'(m_tvalid), 64'(0));
    for (int s = 0; s < 4; s++) begin
      bus_wsel = 2'(s);
      #1 check(bus_wready == 1'b1, "R1", "wready after reset", 64'(bus_wready), 64'(1));
    end

    // R2: sideband write alone makes no beat
    tag = "R2";
    bus_write(2'd1, 32'h0402_0081);
    #1 check(m_tvalid == 1'b0, "R2", "beat after sideband write", 64'(m_tvalid), 64'(0));

    // R10: beat visible right after the accepting edge
    tag = "R10";
    bus_write(2'd0, 32'hA1B2_C3D4);
    #1 check(m_tvalid == 1'b1, "R10", "tvalid after payload write", 64'(m_tvalid), 64'(1));
    check(m_tdata == 32'hD4C3_B2A1, "R4", "lane order", 64'(m_tdata), 64'hD4C3B2A1);
    // R2: same held sideband reused
    tag = "R2";
    bus_write(2'd0, 32'h1122_3344);
    drain();

    // R3: length and unused slot make no beat and keep sideband
    tag = "R3";
    bus_write(2'd2, 32'd60);
    #1 check(m_tvalid == 1'b0, "R3", "beat after length write", 64'(m_tvalid), 64'(0));
    bus_write(2'd3, 32'hFFFF_FFFF);
    #1 check(m_tvalid == 1'b0, "R3", "beat after unused write", 64'(m_tvalid), 64'(0));
    bus_write(2'd0, 32'h5566_7788);
    #1 check(m_tuser == 16'h0402 && m_tkeep == 4'h1 && m_tlast == 1'b1, "R3",
             "sideband kept", 64'({m_tuser, m_tlast, m_tkeep}), 64'({16'h0402, 1'b1, 4'h1}));
    drain();

    // R4/R5: sweep every port pair and strobe width, with junk in ignored bits
    tag = "R5";
    m_tready = 1'b1;
    for (int d = 0; d < 8; d++) begin
      for (int s = 0; s < 8; s++) begin
        int n;
        logic [31:0] sb;
        n = ((d + s) % 4) + 1;
        sb = (32'(1 << d) << 24) | (32'(1 << s) << 16) | (32'(d * 8 + s) << 8)
           | ((s == 7) ? 32'h80 : 32'h0) | 32'h70 | 32'((1 << n) - 1);
        bus_write(2'd1, sb);
        bus_write(2'd0, 32'h0102_0304 * 32'(d * 8 + s + 1));
      end
    end
    drain();

    // R8: full buffer stalls only payload writes
    tag = "R8";
    for (int i = 0; i < DEPTH; i++) bus_write(2'd0, 32'h1000_0000 + 32'(i));
    @(negedge clk);
    bus_wsel = 2'd0;
    #1 check(bus_wready == 1'b0, "R8", "wready payload when full", 64'(bus_wready), 64'(0));
    bus_wsel = 2'd1;
    #1 check(bus_wready == 1'b1, "R8", "wready sideband when full", 64'(bus_wready), 64'(1));
    first_data = m_tdata;
    fork
      bus_write(2'd0, 32'hDEAD_BEEF);
      begin
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          #2;
          // R7
          check(m_tvalid == 1'b1 && m_tdata == first_data, "R7", "held beat",
                64'(m_tdata), 64'(first_data));
        end
        @(negedge clk);
        m_tready = 1'b1;
      end
    join
    drain();
    check(exp_q.size() == 0, "R8", "stalled write delivered", 64'(exp_q.size()), 64'(0));

    // R9: push and pop in the same cycle
    tag = "R9";
    for (int i = 0; i < 3; i++) bus_write(2'd0, 32'h2000_0000 + 32'(i));
    base = beats_seen;
    @(negedge clk);
    m_tready = 1'b1;
    bus_wvalid = 1'b1;
    bus_wsel = 2'd0;
    bus_wdata = 32'h3000_0003;
    exp_q.push_back(expect_beat(held_sb, 32'h3000_0003));
    @(negedge clk);
    bus_wvalid = 1'b0;
    drain();
    check(beats_seen - base == 4, "R9", "beats out", 64'(beats_seen - base), 64'(4));
    check(exp_q.size() == 0, "R6", "all beats delivered", 64'(exp_q.size()), 64'(0));

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule